// File: doc/BRIEF.md
# Circular Sample Buffer with Hex Text Streamer

This block captures a stream of 16-bit samples into a dual-port circular RAM at whatever rate the producer presents them, one word per `wr_valid` strobe. The write pointer wraps at the end of the buffer, and writes never wait on anything.

A separate reader walks the same RAM continuously, one address per text line, and wraps forever. Each word goes out on a serial line as a short ASCII line: a one-character prefix, five uppercase hex digits, then carriage return and line feed. The prefix tells the host which line is address 0, so it can cut the endless stream into whole buffer blocks.

The buffer holds 2**ADDR_W words; a 16384-entry build uses ADDR_W=14. With a 25 MHz clock the default of 651 clocks per bit gives 38400 baud.

Top module: `hexline_streamer`

## Requirements
- R1: `txd` is high (idle) while `rst_n` is low and in the first cycle after reset is released.
- R2: Each character is one frame, LSB first: a low start bit, 8 data bits, no parity, and a high stop bit. Every bit lasts CLKS_PER_BIT clocks.
- R3: Each cycle with `wr_valid` high stores `wr_data` at the write pointer, then advances the pointer by one. The pointer wraps from 2**ADDR_W-1 to 0, and with `wr_valid` low it holds.
- R4: After reset the reader begins at address 0. It advances by exactly one address per line, returns to 0 after the last address, and keeps cycling.
- R5: A line is eight characters: the prefix, then five hex digits of the word zero-extended to 20 bits (most significant digit first), then CR (0x0D), then LF (0x0A).
- R6: The prefix is 'G' (0x47) on the line for address 0 and 'x' (0x78) on every other line.
- R7: Hex digits are ASCII '0'-'9' (0x30-0x39) for values 0-9 and uppercase 'A'-'F' (0x41-0x46) for values 10-15.
- R8: A write to an address that already holds data replaces it. A line shows whatever the RAM held when that line's word was fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both buffer sides and the serializer |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Sample strobe; one word is stored per high cycle |
| wr_data | input | DATA_W (16) | Sample word to store |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The samples mix all-zero, all-ones, digits-only and letters-only nibbles, so the bench can tell a wrong ASCII offset for letters from a wrong offset for digits. A misordered nibble shows up as well. Writing one word more than the buffer depth overwrites address 0, and that value must appear on the next 'G' line, which separates a wrapping write pointer from one that stalls or overruns. The bench then follows the reader past the last address and back to address 1, which shows that the read side wraps and keeps streaming.

// File: rtl/hexline_pkg.sv
package hexline_pkg;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_CAPTURE,
        ST_LOAD,
        ST_WAIT
    } line_state_t;

    localparam logic [7:0] CH_START = 8'h47;
    localparam logic [7:0] CH_OTHER = 8'h78;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    function automatic logic [7:0] nibble_to_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/sample_ram.sv
module sample_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/uart_serializer.sv
module uart_serializer #(
    parameter int CLKS_PER_BIT = 651
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    localparam int CNT_W    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int FRAME_EB = 9;

    logic [CNT_W-1:0] cyc_cnt;
    logic [3:0]       bit_cnt;
    logic [8:0]       shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            txd     <= 1'b1;
            cyc_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '1;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                txd     <= 1'b0;
                shreg   <= {1'b1, data};
                cyc_cnt <= '0;
                bit_cnt <= '0;
            end
        end else if (cyc_cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
            cyc_cnt <= '0;
            if (bit_cnt == 4'(FRAME_EB)) begin
                busy <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 4'd1;
                txd     <= shreg[0];
                shreg   <= {1'b1, shreg[8:1]};
            end
        end else begin
            cyc_cnt <= cyc_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/hexline_streamer.sv
module hexline_streamer #(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 11,
    parameter int HEX_DIGITS   = 5,
    parameter int CLKS_PER_BIT = 651
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd
);
    import hexline_pkg::*;

    localparam int EXT_W    = 4 * HEX_DIGITS;
    localparam int LINE_LEN = HEX_DIGITS + 3;
    localparam int IDX_W    = $clog2(LINE_LEN);

    line_state_t       state, state_nx;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [DATA_W-1:0] rd_data, word_q;
    logic [IDX_W-1:0]  char_idx;
    logic [EXT_W-1:0]  word_ext;
    logic [7:0]        char_out;
    logic [7:0]        digit_char [HEX_DIGITS];
    logic              tx_start, tx_busy, last_char;

    sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk  (clk),
        .we   (wr_valid),
        .waddr(wr_ptr),
        .wdata(wr_data),
        .raddr(rd_ptr),
        .rdata(rd_data)
    );

    uart_serializer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tx_start),
        .data (char_out),
        .busy (tx_busy),
        .txd  (txd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wr_ptr <= '0;
        else if (wr_valid) wr_ptr <= wr_ptr + ADDR_W'(1);
    end

    assign word_ext  = EXT_W'(word_q);
    assign last_char = (char_idx == IDX_W'(LINE_LEN - 1));

    generate
        for (genvar d = 0; d < HEX_DIGITS; d++) begin : g_digit
            assign digit_char[d] =
                nibble_to_ascii(word_ext[EXT_W-1-4*d -: 4]);
        end
    endgenerate

    always_comb begin
        char_out = CH_LF;
        if (char_idx == '0)
            char_out = (rd_ptr == '0) ? CH_START : CH_OTHER;
        else if (char_idx <= IDX_W'(HEX_DIGITS))
            char_out = digit_char[char_idx - IDX_W'(1)];
        else if (char_idx == IDX_W'(HEX_DIGITS + 1))
            char_out = CH_CR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:   state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_LOAD;
            ST_LOAD:    if (!tx_busy) state_nx = ST_WAIT;
            ST_WAIT:    if (!tx_busy) state_nx = last_char ? ST_FETCH : ST_LOAD;
        endcase
    end

    always_comb begin
        tx_start = (state == ST_LOAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            word_q   <= '0;
            char_idx <= '0;
        end else begin
            unique case (state)
                ST_FETCH: ;
                ST_CAPTURE: begin
                    word_q   <= rd_data;
                    char_idx <= '0;
                end
                ST_LOAD: ;
                ST_WAIT: if (!tx_busy) begin
                    if (last_char) rd_ptr <= rd_ptr + ADDR_W'(1);
                    else           char_idx <= char_idx + IDX_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/hexline_streamer_checker.sv
module hexline_streamer_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic              tx_busy,
    input logic              txd
);
    assert_wr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1));

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(wr_ptr));

    assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_ptr) |-> rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1));

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);
endmodule

bind hexline_streamer hexline_streamer_checker #(.ADDR_W(ADDR_W)) chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .tx_busy (tx_busy),
    .txd     (txd)
);

// File: tb/hexline_streamer_test.sv
module hexline_streamer_test;
    localparam int CPB    = 8;
    localparam int AW     = 3;
    localparam int NWORDS = 1 << AW;

    localparam logic [15:0] VEC [NWORDS] = '{
        16'h07B1, 16'h0E80, 16'hFFFF, 16'h0000,
        16'hA5C3, 16'h1234, 16'hBCDE, 16'h6789
    };
    localparam logic [15:0] OVERWRITE = 16'hF00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        txd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hexline_streamer #(.DATA_W(16), .ADDR_W(AW), .HEX_DIGITS(5),
                       .CLKS_PER_BIT(CPB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
        .wr_data(wr_data), .txd(txd)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n);
        string digits = "0123456789ABCDEF";
        return digits[n];
    endfunction

    task automatic get_char(output logic [7:0] c);
        c = '0;
        while (txd !== 1'b0) @(negedge clk);
        repeat (CPB / 2) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            repeat (CPB) @(negedge clk);
            c[b] = txd;
        end
        repeat (CPB) @(negedge clk);
        check(txd === 1'b1, "R2 stop bit", {31'd0, txd}, 32'd1);
    endtask

    task automatic expect_line(input bit is_first, input logic [15:0] w,
                               input string tag);
        logic [7:0] c;
        logic [7:0] exp [8];
        exp[0] = is_first ? 8'h47 : 8'h78;
        exp[1] = 8'h30;
        exp[2] = hexch(w[15:12]);
        exp[3] = hexch(w[11:8]);
        exp[4] = hexch(w[7:4]);
        exp[5] = hexch(w[3:0]);
        exp[6] = 8'h0D;
        exp[7] = 8'h0A;
        for (int k = 0; k < 8; k++) begin
            get_char(c);
            if (k == 0)
                check(c == exp[k], {tag, " R6 prefix"}, {24'd0, c}, {24'd0, exp[k]});
            else if (k < 6)
                check(c == exp[k], {tag, " R5 R7 digit"}, {24'd0, c}, {24'd0, exp[k]});
            else
                check(c == exp[k], {tag, " R5 line end"}, {24'd0, c}, {24'd0, exp[k]});
        end
    endtask

    task automatic skip_line();
        logic [7:0] c;
        for (int k = 0; k < 8; k++) get_char(c);
    endtask

    task automatic write_word(input logic [15:0] v);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(txd === 1'b1, "R1 idle during reset", {31'd0, txd}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R1 idle after reset", {31'd0, txd}, 32'd1);
        fork
            begin
                for (int i = 0; i < NWORDS; i++) write_word(VEC[i]);
                write_word(OVERWRITE);
            end
            skip_line();
        join
        for (int i = 1; i < NWORDS; i++)
            expect_line(1'b0, VEC[i], "R4 sequence");
        expect_line(1'b1, OVERWRITE, "R3 R8 wrap overwrite");
        expect_line(1'b0, VEC[1], "R4 read wrap");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule